// File: doc/BRIEF.md
# Sub-Addressed I2C Write Register Bank

This block is a write-only I2C target that fills a bank of 8-bit control registers at sub-addresses 0x40 to 0x56. SCL and SDA are first brought into the system clock domain. The block then finds start and stop conditions and shifts in the bits of each byte. It compares the first byte with its own 7-bit address and pulls SDA low during the acknowledge clock of every byte it accepts. The whole register bank is available in parallel on one output bus. One switch-control output copies a single bit of register 0x4D.

After the address byte, the first sub-address byte selects how the rest of the transfer is read. When its top bit is clear, the following bytes alternate between sub-address and data until the transfer ends. When its top bit is set, its lower seven bits give a start address, and every byte after it is data for the next address up. A target address that does not match, or a read request, makes the block leave the bus alone until the next start.

Top module: `i2c_subaddr_regfile`

## Requirements
- R1: After reset all registers read 0x00, `sw_ctrl_o` is low and `sda_low_o` is low.
- R2: When an address byte carries the block's 7-bit address with the direction bit 0 (write), that byte and every later byte of the transfer are acknowledged: `sda_low_o` is high during the ninth SCL clock of the byte. The pull only starts while SCL is low.
- R3: If the address does not match, or the direction bit is 1, the block gives no acknowledge and changes no register for the rest of the transfer, up to the next start.
- R4: If bit 7 of the first sub-address byte is 0, the bytes that follow alternate: sub-address (bits 6:0 used), then data written to it, then the next sub-address, and so on.
- R5: If bit 7 of the first sub-address byte is 1, bits 6:0 give the start address. Every following byte is written to that address plus 0, 1, 2 and so on.
- R6: A data byte for an address outside 0x40..0x56 is acknowledged but changes no register. This includes a burst that runs past 0x56.
- R7: `sw_ctrl_o` equals bit 6 of register 0x4D.
- R8: A stop condition ends the transfer, and bytes clocked while no transfer is open are ignored. A repeated start begins a new address phase.
- R9: A written register shows its new value on `regs_o` from the 5th clock edge after SCL rises for the byte's 8th bit. The acknowledge pull begins on the 3rd edge after the SCL fall that ends bit 8. It ends on the 3rd edge after the SCL fall that ends the 9th clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_low_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| sw_ctrl_o | output | 1 | Switch-control output, bit 6 of register 0x4D |
| regs_o | output | NREG*8 | Register bank; register BASE+i is at bits [8i+7:8i] |

## Verification
The bench model schedules each result at a fixed number of clock edges after the bus edge that causes it. A register write is due 5 edges after the SCL rise of bit 8. The start of the acknowledge pull is due 3 edges after the fall that ends bit 8, and its release 3 edges after the fall that ends the 9th clock. The model holds these as timed events and compares the full register bus, the switch output and the SDA pull against them on every falling clock edge. A delay that is one edge early or one edge late therefore shows up as a mismatch. Separate named checks sample the wired SDA line halfway through each acknowledge clock, and read registers back after each transfer.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_SUB1,
      ST_SUB,
      ST_DATA,
      ST_SKIP
   } link_state_t;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2cw_sync needs at least two stages");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cw_bitphy.sv
module i2cw_bitphy (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl,
   input  logic       sda,
   input  logic       ack_req,
   output logic       start_p,
   output logic       stop_p,
   output logic       byte_p,
   output logic [7:0] byte_o,
   output logic       sda_low_o
);
   logic       scl_q, sda_q;
   logic       scl_rise, scl_fall, start_c, stop_c;
   logic [3:0] bit_cnt;
   logic       in_ack, active;
   logic [7:0] shreg;

   assign scl_rise = scl & ~scl_q;
   assign scl_fall = ~scl & scl_q;
   assign start_c  = scl & scl_q & sda_q & ~sda;
   assign stop_c   = scl & scl_q & ~sda_q & sda;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q     <= 1'b1;
         sda_q     <= 1'b1;
         start_p   <= 1'b0;
         stop_p    <= 1'b0;
         byte_p    <= 1'b0;
         bit_cnt   <= '0;
         in_ack    <= 1'b0;
         active    <= 1'b0;
         shreg     <= '0;
         sda_low_o <= 1'b0;
      end else begin
         scl_q   <= scl;
         sda_q   <= sda;
         start_p <= start_c;
         stop_p  <= stop_c;
         byte_p  <= 1'b0;
         if (start_c || stop_c) begin
            bit_cnt   <= '0;
            in_ack    <= 1'b0;
            sda_low_o <= 1'b0;
            active    <= start_c;
         end else if (active) begin
            if (scl_rise && !in_ack && bit_cnt < 4'd8) begin
               shreg   <= {shreg[6:0], sda};
               bit_cnt <= bit_cnt + 4'd1;
               if (bit_cnt == 4'd7) byte_p <= 1'b1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
               if (!in_ack) begin
                  in_ack    <= 1'b1;
                  sda_low_o <= ack_req;
               end else begin
                  in_ack    <= 1'b0;
                  sda_low_o <= 1'b0;
                  bit_cnt   <= '0;
               end
            end
         end
      end
   end

   assign byte_o = shreg;

   AST_ACK_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_low_o) |-> !scl); // R2
   AST_ACK_ENDS_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_low_o) |-> ($past(scl_fall) || $past(start_c) || $past(stop_c))); // R9
endmodule

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
   import i2cw_pkg::*;
#(
   parameter logic [6:0] SLAVE_ADDR = 7'h5A
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_p,
   input  logic       stop_p,
   input  logic       byte_p,
   input  logic [7:0] byte_i,
   output logic       ack_req,
   output logic       wr_en,
   output logic [7:0] wr_addr,
   output logic [7:0] wr_data
);
   link_state_t state;
   logic [7:0]  ptr;
   logic        burst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         ptr     <= '0;
         burst   <= 1'b0;
         ack_req <= 1'b0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (start_p) begin
            state   <= ST_ADDR;
            ack_req <= 1'b0;
         end else if (stop_p) begin
            state   <= ST_IDLE;
            ack_req <= 1'b0;
         end else if (byte_p) begin
            unique case (state)
               ST_ADDR: begin
                  if (byte_i[7:1] == SLAVE_ADDR && !byte_i[0]) begin
                     state   <= ST_SUB1;
                     ack_req <= 1'b1;
                  end else begin
                     state   <= ST_SKIP;
                     ack_req <= 1'b0;
                  end
               end
               ST_SUB1: begin
                  burst   <= byte_i[7];
                  ptr     <= {1'b0, byte_i[6:0]};
                  state   <= ST_DATA;
                  ack_req <= 1'b1;
               end
               ST_SUB: begin
                  ptr     <= {1'b0, byte_i[6:0]};
                  state   <= ST_DATA;
                  ack_req <= 1'b1;
               end
               ST_DATA: begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= byte_i;
                  ack_req <= 1'b1;
                  if (burst) ptr   <= ptr + 8'd1;
                  else       state <= ST_SUB;
               end
               default: ack_req <= 1'b0;
            endcase
         end
      end
   end

   AST_SKIP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |=> !wr_en); // R3
   AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_p && !start_p && !stop_p && state == ST_DATA && burst) |=> (ptr == $past(ptr) + 8'd1)); // R5
   AST_ALT_BACK_TO_SUB: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_p && !start_p && !stop_p && state == ST_DATA && !burst) |=> (state == ST_SUB)); // R4
   AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_p && !start_p) |=> (state == ST_IDLE)); // R8
endmodule

// File: rtl/i2cw_regbank.sv
module i2cw_regbank #(
   parameter int BASE = 'h40,
   parameter int NREG = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        wr_addr,
   input  logic [7:0]        wr_data,
   output logic [NREG*8-1:0] regs_o
);
   logic [NREG-1:0] hit;

   for (genvar i = 0; i < NREG; i++) begin : g_dec
      assign hit[i] = wr_en && (int'(wr_addr) == BASE + i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs_o <= '0;
      end else begin
         for (int i = 0; i < NREG; i++) begin
            if (hit[i]) regs_o[i*8 +: 8] <= wr_data;
         end
      end
   end

   AST_OOR_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ((int'(wr_addr) < BASE) || (int'(wr_addr) >= BASE + NREG))) |=> $stable(regs_o)); // R6
   AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit)); // R4
endmodule

// File: rtl/i2c_subaddr_regfile.sv
module i2c_subaddr_regfile #(
   parameter logic [6:0] SLAVE_ADDR  = 7'h5A,
   parameter int         BASE        = 'h40,
   parameter int         NREG        = 23,
   parameter int         SW_REG      = 'h4D,
   parameter int         SW_BIT      = 6,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_low_o,
   output logic              sw_ctrl_o,
   output logic [NREG*8-1:0] regs_o
);
   localparam int SW_IDX = (SW_REG - BASE) * 8 + SW_BIT;

   if (NREG < 1 || BASE < 0 || BASE + NREG > 128) begin : g_bad_range
      $error("register window must lie inside 0x00..0x7F");
   end
   if (SW_REG < BASE || SW_REG >= BASE + NREG || SW_BIT < 0 || SW_BIT > 7) begin : g_bad_sw
      $error("switch bit must lie inside the register window");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("at least two synchroniser stages are required");
   end

   logic [1:0] bus_s;
   logic       start_p, stop_p, byte_p, ack_req, wr_en;
   logic [7:0] byte_v, wr_addr, wr_data;

   i2cw_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s)
   );

   i2cw_bitphy u_phy (
      .clk(clk), .rst_n(rst_n), .scl(bus_s[1]), .sda(bus_s[0]),
      .ack_req(ack_req), .start_p(start_p), .stop_p(stop_p),
      .byte_p(byte_p), .byte_o(byte_v), .sda_low_o(sda_low_o)
   );

   i2cw_ctrl #(.SLAVE_ADDR(SLAVE_ADDR)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_p(start_p), .stop_p(stop_p),
      .byte_p(byte_p), .byte_i(byte_v), .ack_req(ack_req),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   i2cw_regbank #(.BASE(BASE), .NREG(NREG)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .regs_o(regs_o)
   );

   assign sw_ctrl_o = regs_o[SW_IDX];

   AST_SW_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sw_ctrl_o) |-> $past(wr_en && int'(wr_addr) == SW_REG)); // R7
endmodule

// File: tb/tb_i2c_subaddr_regfile.sv
module tb_i2c_subaddr_regfile;
   localparam logic [6:0] ADDR = 7'h5A;
   localparam int BASE = 'h40;
   localparam int NREG = 23;
   localparam int Q    = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_line;
   logic sda_low_o, sw_ctrl_o;
   logic [NREG*8-1:0] regs_o;

   int total = 0;
   int fails = 0;
   int cyc = 0;
   bit run = 0;

   logic [7:0] exp_reg [NREG];
   bit exp_ack = 0;
   int ev_due[$], ev_kind[$], ev_a[$], ev_v[$];

   int m_state = 0;
   int m_ptr = 0;
   bit m_burst = 0;

   always #10 clk = ~clk;
   assign sda_line = sda_m & ~sda_low_o;

   i2c_subaddr_regfile #(.SLAVE_ADDR(ADDR)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_low_o(sda_low_o), .sw_ctrl_o(sw_ctrl_o), .regs_o(regs_o)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int rd(input int a);
      return int'(regs_o[(a-BASE)*8 +: 8]);
   endfunction

   // R9: cycle-exact comparison against timed model events
   always @(negedge clk) begin
      if (rst_n && run) begin
         while (ev_due.size() > 0 && ev_due[0] <= cyc) begin
            if (ev_kind[0] == 0) begin
               if (ev_a[0] >= BASE && ev_a[0] < BASE + NREG) exp_reg[ev_a[0]-BASE] = 8'(ev_v[0]);
            end else begin
               exp_ack = (ev_v[0] != 0);
            end
            void'(ev_due.pop_front()); void'(ev_kind.pop_front());
            void'(ev_a.pop_front());   void'(ev_v.pop_front());
         end
         begin
            logic [NREG*8-1:0] flat;
            for (int i = 0; i < NREG; i++) flat[i*8 +: 8] = exp_reg[i];
            total++;
            if (flat !== regs_o || sda_low_o !== exp_ack || sw_ctrl_o !== exp_reg['h4D-BASE][6]) begin
               fails++;
               $display("FAIL R9 cycle %0d actual regs=%h ack=%b sw=%b expected regs=%h ack=%b",
                        cyc, regs_o, sda_low_o, sw_ctrl_o, flat, exp_ack);
            end
         end
      end
   end

   task automatic push_ev(input int due, input int kind, input int a, input int v);
      ev_due.push_back(due); ev_kind.push_back(kind); ev_a.push_back(a); ev_v.push_back(v);
   endtask

   task automatic model_byte(input logic [7:0] b, input int c, output bit ack);
      ack = 0;
      case (m_state)
         1: if (b[7:1] == ADDR && !b[0]) begin m_state = 2; ack = 1; end
            else m_state = 5;
         2: begin m_burst = b[7]; m_ptr = int'(b[6:0]); m_state = 4; ack = 1; end
         3: begin m_ptr = int'(b[6:0]); m_state = 4; ack = 1; end
         4: begin
               push_ev(c + 5, 0, m_ptr, int'(b));
               if (m_burst) m_ptr++; else m_state = 3;
               ack = 1;
            end
         default: ack = 0;
      endcase
   endtask

   task automatic waitq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; waitq(Q); scl_m = 1'b1; waitq(Q);
      sda_m = 1'b0; m_state = 1; waitq(Q);
      scl_m = 1'b0; waitq(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; waitq(Q); scl_m = 1'b1; waitq(Q);
      sda_m = 1'b1; m_state = 0; waitq(2*Q);
   endtask

   task automatic send_byte(input logic [7:0] b, input string tag);
      bit ack;
      ack = 0;
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; waitq(Q);
         scl_m = 1'b1;
         if (i == 0) model_byte(b, cyc, ack);
         waitq(2*Q);
         scl_m = 1'b0;
         if (i == 0) push_ev(cyc + 3, 1, 0, int'(ack));
         waitq(Q);
      end
      sda_m = 1'b1; waitq(Q);
      scl_m = 1'b1; waitq(Q);
      chk(tag, int'(sda_line), ack ? 0 : 1);
      waitq(Q);
      scl_m = 1'b0; push_ev(cyc + 3, 1, 0, 0);
      waitq(Q);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      for (int i = 0; i < NREG; i++) exp_reg[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      run = 1;
      @(negedge clk);
      chk("R1 regs zero", int'(regs_o != '0), 0);
      chk("R1 sw low", int'(sw_ctrl_o), 0);
      chk("R1 sda released", int'(sda_low_o), 0);

      // alternating sub-address / data
      bus_start();
      send_byte({ADDR, 1'b0}, "R2 address ack");
      send_byte(8'h41, "R4 sub ack");
      send_byte(8'hA5, "R4 data ack");
      send_byte(8'h4D, "R4 sub ack");
      send_byte(8'h40, "R4 data ack");
      send_byte(8'h56, "R4 sub ack");
      send_byte(8'h3C, "R4 data ack");
      bus_stop();
      chk("R4 reg41", rd('h41), 'hA5);
      chk("R4 reg56", rd('h56), 'h3C);
      chk("R7 sw high", int'(sw_ctrl_o), 1);

      // burst
      bus_start();
      send_byte({ADDR, 1'b0}, "R2 address ack");
      send_byte(8'hC4, "R5 sub ack");
      send_byte(8'h11, "R5 data ack");
      send_byte(8'h22, "R5 data ack");
      send_byte(8'h33, "R5 data ack");
      bus_stop();
      chk("R5 reg44", rd('h44), 'h11);
      chk("R5 reg45", rd('h45), 'h22);
      chk("R5 reg46", rd('h46), 'h33);
      chk("R5 reg47 untouched", rd('h47), 'h00);

      // burst past the top and out-of-range alternate write
      bus_start();
      send_byte({ADDR, 1'b0}, "R2 address ack");
      send_byte(8'hD5, "R6 sub ack");
      send_byte(8'h77, "R6 data ack");
      send_byte(8'h88, "R6 data ack");
      send_byte(8'h99, "R6 out-of-range data ack");
      bus_stop();
      bus_start();
      send_byte({ADDR, 1'b0}, "R2 address ack");
      send_byte(8'h20, "R6 sub ack");
      send_byte(8'hFF, "R6 out-of-range data ack");
      bus_stop();
      chk("R6 reg55", rd('h55), 'h77);
      chk("R6 reg56", rd('h56), 'h88);
      chk("R6 reg40 kept", rd('h40), 'h00);

      // wrong address, then read request
      bus_start();
      send_byte({ADDR ^ 7'h01, 1'b0}, "R3 no ack wrong address");
      send_byte(8'h41, "R3 no ack");
      send_byte(8'h00, "R3 no ack");
      bus_stop();
      chk("R3 reg41 kept", rd('h41), 'hA5);
      bus_start();
      send_byte({ADDR, 1'b1}, "R3 no ack read");
      send_byte(8'h00, "R3 no ack");
      bus_stop();

      // repeated start
      bus_start();
      send_byte({ADDR, 1'b0}, "R2 address ack");
      send_byte(8'h4D, "R8 sub ack");
      send_byte(8'h00, "R8 data ack");
      bus_start();
      send_byte({ADDR, 1'b0}, "R8 address ack after repeated start");
      send_byte(8'hC0, "R8 sub ack");
      send_byte(8'h12, "R8 data ack");
      bus_stop();
      chk("R7 sw low", int'(sw_ctrl_o), 0);
      chk("R8 reg40", rd('h40), 'h12);

      // bytes with no open transfer
      send_byte({ADDR, 1'b0}, "R8 idle no ack");
      send_byte(8'h41, "R8 idle no ack");
      send_byte(8'h00, "R8 idle no ack");
      waitq(2*Q);
      chk("R8 reg41 kept", rd('h41), 'hA5);

      waitq(20);
      run = 0;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule